// File: doc/BRIEF.md
# Video DRAM Strobe-Decoded Special-Function Controller

This block is a clocked behavioural model of the random-access side of a video DRAM. It samples the active-low row strobe, column strobe and transfer strobe, the two byte write enables and a special-function select on every clock. From the falling edges of these strobes it works out which kind of access is under way: a load or read of a 16-bit color register, a load or read of a 16-bit write-mask register, a flash write that paints a whole row with the color value, or a plain array access that reads or writes one 16-bit location.

Each bit of the color and mask registers belongs to one I/O block of the array. A flash write updates only the I/O blocks whose mask bit is set and leaves the others as they were. The array is small: `2**ROW_W` rows of `2**COL_W` columns of 16 bits. The row address is taken at the row-strobe fall and the column address at the column-strobe fall. The data bus is split into an input, an output and an output enable. The enable marks the cycles in which the model drives the shared bus.

Top module: `vdram_sf_decoder`

## Requirements
- R1: A register cycle starts when `ras_n` falls while `cas_n`, `trg_n`, `wel_n`, `weu_n` and `dsf` are all high. At the next `cas_n` fall, `dsf`=1 selects the color register and `dsf`=0 selects the mask register.
- R2: A register cycle is a load when `wel_n` or `weu_n` is low at the `cas_n` fall, or when either one falls later while `cas_n` is still low. `dq_in` is captured into the selected register on the clock that sees the later of the two falls. Outside a load, both registers hold their values.
- R3: A register cycle is a read when both write enables are high at the `cas_n` fall. From the next clock on, `dq_out` shows the selected register.
- R4: `dq_oe` is high only in a read (register or array) while `ras_n` and `cas_n` are both low. It drops in the same cycle that either strobe rises. `dq_out` is zero whenever `dq_oe` is low.
- R5: `rfsh` pulses for one clock, in the cycle after the `ras_n` fall of a register cycle, with `rfsh_row` set to the row address latched at that fall. It stays low for all other cycle types.
- R6: A flash write happens when `ras_n` falls while `cas_n`, `trg_n` and `dsf` are high and `wel_n` and `weu_n` are both low. Every column of the addressed row then becomes (color AND mask) OR (old AND NOT mask).
- R7: A plain cycle starts when `ras_n` falls with `dsf` low and the other four strobes high. The `cas_n` fall latches the column. If a write enable is low at that fall, the location is written with no mask: `wel_n` low writes bits 7:0 and `weu_n` low writes bits 15:8. If both are high, the location is read onto `dq_out`.
- R8: Decode state clears when `ras_n` rises, and a new cycle type is chosen only at a `ras_n` fall. A `cas_n` fall while `ras_n` is high changes nothing. Any other strobe pattern at the `ras_n` fall (for example `trg_n` low) makes the whole cycle a no-operation.
- R9: After reset both registers and the whole array are zero, `dq_oe` is low and `rfsh` is low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Sampling clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ras_n | input | 1 | Row strobe, active low |
| cas_n | input | 1 | Column strobe, active low |
| trg_n | input | 1 | Transfer/output strobe, active low |
| wel_n | input | 1 | Write enable for the low byte, active low |
| weu_n | input | 1 | Write enable for the high byte, active low |
| dsf | input | 1 | Special-function select |
| addr | input | AW | Row address at the row-strobe fall, column address at the column-strobe fall |
| dq_in | input | DQ_W | Data bus, inbound |
| dq_out | output | DQ_W | Data bus, outbound |
| dq_oe | output | 1 | Output enable for the data bus |
| rfsh | output | 1 | One-clock pulse when a register cycle refreshes a row |
| rfsh_row | output | ROW_W | Row refreshed by the register cycle |

## Verification
The bench goes after the late write enable in a register cycle. A design that latched data only at the column-strobe fall would miss the value there, or would keep driving the bus after the enable fell. Flash writes are run over locations that already hold a mixed pattern and under a partial mask, so a design that ignored the mask, or cleared the masked-off blocks, returns wrong words from the untouched I/O blocks. Strobe patterns that are not legal at the row-strobe fall, and column-strobe falls with the row strobe high, are checked to leave the registers unchanged. Bus-enable timing is checked in the exact cycle a strobe rises, which catches an enable that is registered one clock too late.

// File: rtl/vdram_pkg.sv
package vdram_pkg;

    typedef enum logic [2:0] {
        S_IDLE,
        S_REG,
        S_REG_RD,
        S_NORM,
        S_NORM_RD,
        S_DONE
    } cyc_state_e;

    typedef enum logic [1:0] {
        SRC_COLOR,
        SRC_MASK,
        SRC_ARRAY
    } rd_src_e;

endpackage

// File: rtl/vdram_strobe_edges.sv
module vdram_strobe_edges (
    input  logic clk,
    input  logic rst_n,
    input  logic ras_n,
    input  logic cas_n,
    input  logic we_low,
    output logic ras_fall,
    output logic ras_rise,
    output logic cas_fall,
    output logic cas_rise,
    output logic we_fall
);

    typedef struct packed {
        logic ras_n;
        logic cas_n;
        logic we_low;
    } prev_t;

    prev_t prev_d, prev_q;

    always_comb begin
        prev_d.ras_n  = ras_n;
        prev_d.cas_n  = cas_n;
        prev_d.we_low = we_low;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            prev_q.ras_n  <= 1'b1;
            prev_q.cas_n  <= 1'b1;
            prev_q.we_low <= 1'b0;
        end else begin
            prev_q <= prev_d;
        end
    end

    assign ras_fall = prev_q.ras_n & ~ras_n;
    assign ras_rise = ~prev_q.ras_n & ras_n;
    assign cas_fall = prev_q.cas_n & ~cas_n;
    assign cas_rise = ~prev_q.cas_n & cas_n;
    assign we_fall  = ~prev_q.we_low & we_low;

endmodule

// File: rtl/vdram_regfile.sv
module vdram_regfile #(
    parameter int DQ_W = 16
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            load_en,
    input  logic            load_color,
    input  logic [DQ_W-1:0] din,
    output logic [DQ_W-1:0] color,
    output logic [DQ_W-1:0] mask
);

    typedef struct packed {
        logic [DQ_W-1:0] color;
        logic [DQ_W-1:0] mask;
    } regs_t;

    regs_t regs_d, regs_q;

    always_comb begin
        regs_d = regs_q;
        if (load_en) begin
            if (load_color) regs_d.color = din;
            else            regs_d.mask  = din;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) regs_q <= '0;
        else        regs_q <= regs_d;
    end

    assign color = regs_q.color;
    assign mask  = regs_q.mask;

    // R2: without a load strobe both registers keep their contents
    p_regs_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
        !load_en |=> ($stable(color) && $stable(mask)));

endmodule

// File: rtl/vdram_array.sv
module vdram_array #(
    parameter int DQ_W  = 16,
    parameter int ROW_W = 3,
    parameter int COL_W = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             flash_go,
    input  logic [ROW_W-1:0] flash_row,
    input  logic [DQ_W-1:0]  color,
    input  logic [DQ_W-1:0]  mask,
    input  logic             wr_go,
    input  logic [1:0]       wr_be,
    input  logic [ROW_W-1:0] wr_row,
    input  logic [COL_W-1:0] wr_col,
    input  logic [DQ_W-1:0]  wr_data,
    input  logic [ROW_W-1:0] rd_row,
    input  logic [COL_W-1:0] rd_col,
    output logic [DQ_W-1:0]  rd_data
);

    localparam int ROWS   = 1 << ROW_W;
    localparam int COLS   = 1 << COL_W;
    localparam int LANE_W = DQ_W / 2;

    logic [DQ_W-1:0] mem_d [ROWS][COLS];
    logic [DQ_W-1:0] mem_q [ROWS][COLS];

    always_comb begin
        mem_d = mem_q;
        if (flash_go) begin
            for (int c = 0; c < COLS; c++) begin
                mem_d[flash_row][c] = (color & mask) | (mem_q[flash_row][c] & ~mask);
            end
        end
        if (wr_go) begin
            for (int l = 0; l < 2; l++) begin
                if (wr_be[l]) begin
                    mem_d[wr_row][wr_col][l*LANE_W +: LANE_W] = wr_data[l*LANE_W +: LANE_W];
                end
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int r = 0; r < ROWS; r++) begin
                for (int c = 0; c < COLS; c++) begin
                    mem_q[r][c] <= '0;
                end
            end
        end else begin
            mem_q <= mem_d;
        end
    end

    assign rd_data = mem_q[rd_row][rd_col];

    // R6/R7: a flash fill and a single-location write never coincide
    p_one_writer_r6: assert property (@(posedge clk) disable iff (!rst_n)
        !(flash_go && wr_go));

endmodule

// File: rtl/vdram_cycle_ctrl.sv
module vdram_cycle_ctrl
    import vdram_pkg::*;
#(
    parameter int ROW_W = 3,
    parameter int COL_W = 2,
    parameter int AW    = 3
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             ras_n,
    input  logic             cas_n,
    input  logic             trg_n,
    input  logic             wel_n,
    input  logic             weu_n,
    input  logic             dsf,
    input  logic [AW-1:0]    addr,
    input  logic             ras_fall,
    input  logic             ras_rise,
    input  logic             cas_fall,
    input  logic             cas_rise,
    input  logic             we_fall,
    output logic             load_en,
    output logic             load_color,
    output logic             flash_go,
    output logic [ROW_W-1:0] flash_row,
    output logic             wr_go,
    output logic [1:0]       wr_be,
    output logic [ROW_W-1:0] acc_row,
    output logic [COL_W-1:0] wr_col,
    output logic [COL_W-1:0] rd_col,
    output logic             rd_en,
    output rd_src_e          rd_src,
    output logic             rfsh,
    output logic [ROW_W-1:0] rfsh_row
);

    typedef struct packed {
        cyc_state_e       st;
        logic [ROW_W-1:0] row;
        logic [COL_W-1:0] col;
        logic             sel_color;
        logic             rfsh;
        logic [ROW_W-1:0] rfsh_row;
    } ctl_t;

    ctl_t ctl_d, ctl_q;

    logic we_low;
    logic pat_reg, pat_flash, pat_norm;

    always_comb begin
        we_low    = ~wel_n | ~weu_n;
        pat_reg   = cas_n & trg_n & wel_n & weu_n & dsf;
        pat_flash = cas_n & trg_n & dsf & ~wel_n & ~weu_n;
        pat_norm  = cas_n & trg_n & wel_n & weu_n & ~dsf;
    end

    always_comb begin
        ctl_d      = ctl_q;
        ctl_d.rfsh = 1'b0;
        load_en    = 1'b0;
        load_color = 1'b0;
        flash_go   = 1'b0;
        wr_go      = 1'b0;
        wr_be      = 2'b00;
        if (ras_rise) begin
            ctl_d.st = S_IDLE;
        end else begin
            case (ctl_q.st)
                S_IDLE: begin
                    if (ras_fall) begin
                        ctl_d.row = addr[ROW_W-1:0];
                        if (pat_reg) begin
                            ctl_d.st       = S_REG;
                            ctl_d.rfsh     = 1'b1;
                            ctl_d.rfsh_row = addr[ROW_W-1:0];
                        end else if (pat_flash) begin
                            flash_go = 1'b1;
                            ctl_d.st = S_DONE;
                        end else if (pat_norm) begin
                            ctl_d.st = S_NORM;
                        end else begin
                            ctl_d.st = S_DONE;
                        end
                    end
                end
                S_REG: begin
                    if (cas_fall) begin
                        ctl_d.sel_color = dsf;
                        if (we_low) begin
                            load_en    = 1'b1;
                            load_color = dsf;
                            ctl_d.st   = S_DONE;
                        end else begin
                            ctl_d.st = S_REG_RD;
                        end
                    end
                end
                S_REG_RD: begin
                    if (we_fall && !cas_n) begin
                        load_en    = 1'b1;
                        load_color = ctl_q.sel_color;
                        ctl_d.st   = S_DONE;
                    end else if (cas_rise) begin
                        ctl_d.st = S_DONE;
                    end
                end
                S_NORM: begin
                    if (cas_fall) begin
                        ctl_d.col = addr[COL_W-1:0];
                        if (we_low) begin
                            wr_go    = 1'b1;
                            wr_be    = {~weu_n, ~wel_n};
                            ctl_d.st = S_DONE;
                        end else begin
                            ctl_d.st = S_NORM_RD;
                        end
                    end
                end
                S_NORM_RD: begin
                    if (cas_rise || we_fall) ctl_d.st = S_DONE;
                end
                S_DONE:  ctl_d.st = S_DONE;
                default: ctl_d.st = S_IDLE;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ctl_q    <= '0;
            ctl_q.st <= S_IDLE;
        end else begin
            ctl_q <= ctl_d;
        end
    end

    always_comb begin
        flash_row = addr[ROW_W-1:0];
        acc_row   = ctl_q.row;
        wr_col    = addr[COL_W-1:0];
        rd_col    = ctl_q.col;
        rd_en     = ((ctl_q.st == S_REG_RD) || (ctl_q.st == S_NORM_RD)) && !cas_n && !ras_n;
        if (ctl_q.st == S_NORM_RD) rd_src = SRC_ARRAY;
        else if (ctl_q.sel_color)  rd_src = SRC_COLOR;
        else                       rd_src = SRC_MASK;
        rfsh      = ctl_q.rfsh;
        rfsh_row  = ctl_q.rfsh_row;
    end

    // R2: one load per row cycle at most
    p_load_once_r2: assert property (@(posedge clk) disable iff (!rst_n)
        load_en |=> !load_en);

    // R8: a rising row strobe always leaves the decoder idle
    p_idle_after_rise_r8: assert property (@(posedge clk) disable iff (!rst_n)
        ras_rise |=> (ctl_q.st == S_IDLE));

    // R6: flash fill only with the row strobe low and both write enables low
    p_flash_strobes_r6: assert property (@(posedge clk) disable iff (!rst_n)
        flash_go |-> (!ras_n && !wel_n && !weu_n && dsf && trg_n));

endmodule

// File: rtl/vdram_sf_decoder.sv
module vdram_sf_decoder
    import vdram_pkg::*;
#(
    parameter int DQ_W  = 16,
    parameter int ROW_W = 3,
    parameter int COL_W = 2,
    parameter int AW    = (ROW_W > COL_W) ? ROW_W : COL_W
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             ras_n,
    input  logic             cas_n,
    input  logic             trg_n,
    input  logic             wel_n,
    input  logic             weu_n,
    input  logic             dsf,
    input  logic [AW-1:0]    addr,
    input  logic [DQ_W-1:0]  dq_in,
    output logic [DQ_W-1:0]  dq_out,
    output logic             dq_oe,
    output logic             rfsh,
    output logic [ROW_W-1:0] rfsh_row
);

    logic ras_fall, ras_rise, cas_fall, cas_rise, we_fall, we_low;
    logic load_en, load_color, flash_go, wr_go, rd_en;
    logic [1:0]       wr_be;
    logic [ROW_W-1:0] flash_row, acc_row;
    logic [COL_W-1:0] wr_col, rd_col;
    logic [DQ_W-1:0]  color, mask, arr_data;
    rd_src_e          rd_src;

    assign we_low = ~wel_n | ~weu_n;

    vdram_strobe_edges u_edges (
        .clk      (clk),
        .rst_n    (rst_n),
        .ras_n    (ras_n),
        .cas_n    (cas_n),
        .we_low   (we_low),
        .ras_fall (ras_fall),
        .ras_rise (ras_rise),
        .cas_fall (cas_fall),
        .cas_rise (cas_rise),
        .we_fall  (we_fall)
    );

    vdram_cycle_ctrl #(.ROW_W(ROW_W), .COL_W(COL_W), .AW(AW)) u_ctrl (
        .clk        (clk),
        .rst_n      (rst_n),
        .ras_n      (ras_n),
        .cas_n      (cas_n),
        .trg_n      (trg_n),
        .wel_n      (wel_n),
        .weu_n      (weu_n),
        .dsf        (dsf),
        .addr       (addr),
        .ras_fall   (ras_fall),
        .ras_rise   (ras_rise),
        .cas_fall   (cas_fall),
        .cas_rise   (cas_rise),
        .we_fall    (we_fall),
        .load_en    (load_en),
        .load_color (load_color),
        .flash_go   (flash_go),
        .flash_row  (flash_row),
        .wr_go      (wr_go),
        .wr_be      (wr_be),
        .acc_row    (acc_row),
        .wr_col     (wr_col),
        .rd_col     (rd_col),
        .rd_en      (rd_en),
        .rd_src     (rd_src),
        .rfsh       (rfsh),
        .rfsh_row   (rfsh_row)
    );

    vdram_regfile #(.DQ_W(DQ_W)) u_regs (
        .clk        (clk),
        .rst_n      (rst_n),
        .load_en    (load_en),
        .load_color (load_color),
        .din        (dq_in),
        .color      (color),
        .mask       (mask)
    );

    vdram_array #(.DQ_W(DQ_W), .ROW_W(ROW_W), .COL_W(COL_W)) u_array (
        .clk       (clk),
        .rst_n     (rst_n),
        .flash_go  (flash_go),
        .flash_row (flash_row),
        .color     (color),
        .mask      (mask),
        .wr_go     (wr_go),
        .wr_be     (wr_be),
        .wr_row    (acc_row),
        .wr_col    (wr_col),
        .wr_data   (dq_in),
        .rd_row    (acc_row),
        .rd_col    (rd_col),
        .rd_data   (arr_data)
    );

    always_comb begin
        dq_oe = rd_en;
        if (!rd_en) begin
            dq_out = '0;
        end else begin
            case (rd_src)
                SRC_COLOR: dq_out = color;
                SRC_MASK:  dq_out = mask;
                default:   dq_out = arr_data;
            endcase
        end
    end

    // R4: the bus is only driven with both strobes low
    p_oe_strobes_r4: assert property (@(posedge clk) disable iff (!rst_n)
        dq_oe |-> (!ras_n && !cas_n));

    // R5: the refresh indication lasts exactly one clock
    p_rfsh_single_r5: assert property (@(posedge clk) disable iff (!rst_n)
        rfsh |=> !rfsh);

endmodule

// File: tb/vdram_sf_decoder_tb.sv
module vdram_sf_decoder_tb_top;

    localparam int CLK_PERIOD = 10;
    localparam int Q          = CLK_PERIOD / 4;

    localparam int M_IDLE = 0, M_REG = 1, M_REG_RD = 2, M_NORM = 3, M_NORM_RD = 4, M_DONE = 5;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        ras_n = 1'b1, cas_n = 1'b1, trg_n = 1'b1, wel_n = 1'b1, weu_n = 1'b1, dsf = 1'b1;
    logic [2:0]  addr = '0;
    logic [15:0] dq_in = '0;
    logic [15:0] dq_out;
    logic        dq_oe, rfsh;
    logic [2:0]  rfsh_row;

    int tests = 0;
    int fails = 0;
    bit done  = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    vdram_sf_decoder dut_i (
        .clk(clk), .rst_n(rst_n), .ras_n(ras_n), .cas_n(cas_n), .trg_n(trg_n),
        .wel_n(wel_n), .weu_n(weu_n), .dsf(dsf), .addr(addr), .dq_in(dq_in),
        .dq_out(dq_out), .dq_oe(dq_oe), .rfsh(rfsh), .rfsh_row(rfsh_row)
    );

    task automatic chk(input string tag, input logic [15:0] act, input logic [15:0] exp);
        tests++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h at %0t", tag, act, exp, $time);
        end
    endtask

    // ---------------- behavioural reference model ----------------
    int          m_st;
    logic        p_ras, p_cas, p_we;
    logic [15:0] m_color, m_mask;
    logic [15:0] m_mem [8][4];
    logic [2:0]  m_row, m_rrow;
    logic [1:0]  m_col;
    logic        m_sel, m_rfsh;

    always @(posedge clk) begin
        if (!rst_n) begin
            m_st = M_IDLE; p_ras = 1; p_cas = 1; p_we = 0;
            m_color = 0; m_mask = 0; m_row = 0; m_rrow = 0; m_col = 0; m_sel = 0; m_rfsh = 0;
            foreach (m_mem[r, c]) m_mem[r][c] = 16'h0;
        end else begin
            bit rfall, rrise, cfall, crise, wlow, wfall;
            rfall = p_ras && !ras_n;  rrise = !p_ras && ras_n;
            cfall = p_cas && !cas_n;  crise = !p_cas && cas_n;
            wlow  = !wel_n || !weu_n; wfall = wlow && !p_we;
            m_rfsh = 0;
            if (rrise) m_st = M_IDLE;
            else if (m_st == M_IDLE && rfall) begin
                m_row = addr;
                if (cas_n && trg_n && wel_n && weu_n && dsf) begin
                    m_st = M_REG; m_rfsh = 1; m_rrow = addr;
                end else if (cas_n && trg_n && dsf && !wel_n && !weu_n) begin
                    for (int c = 0; c < 4; c++)
                        m_mem[addr][c] = (m_color & m_mask) | (m_mem[addr][c] & ~m_mask);
                    m_st = M_DONE;
                end else if (cas_n && trg_n && wel_n && weu_n && !dsf) m_st = M_NORM;
                else m_st = M_DONE;
            end else if (m_st == M_REG && cfall) begin
                m_sel = dsf;
                if (wlow) begin
                    if (dsf) m_color = dq_in; else m_mask = dq_in;
                    m_st = M_DONE;
                end else m_st = M_REG_RD;
            end else if (m_st == M_REG_RD) begin
                if (wfall && !cas_n) begin
                    if (m_sel) m_color = dq_in; else m_mask = dq_in;
                    m_st = M_DONE;
                end else if (crise) m_st = M_DONE;
            end else if (m_st == M_NORM && cfall) begin
                m_col = addr[1:0];
                if (wlow) begin
                    if (!wel_n) m_mem[m_row][addr[1:0]][7:0]  = dq_in[7:0];
                    if (!weu_n) m_mem[m_row][addr[1:0]][15:8] = dq_in[15:8];
                    m_st = M_DONE;
                end else m_st = M_NORM_RD;
            end else if (m_st == M_NORM_RD && (crise || wfall)) m_st = M_DONE;
            p_ras = ras_n; p_cas = cas_n; p_we = wlow;
        end
    end

    // compare against the model a quarter period after each edge
    always @(posedge clk) begin
        #(Q);
        if (rst_n && !done) begin
            logic        e_oe;
            logic [15:0] e_dq;
            e_oe = (m_st == M_REG_RD || m_st == M_NORM_RD) && !cas_n && !ras_n;
            if (!e_oe)                e_dq = 16'h0;
            else if (m_st == M_NORM_RD) e_dq = m_mem[m_row][m_col];
            else                      e_dq = m_sel ? m_color : m_mask;
            chk("R4 model dq_oe", {15'h0, dq_oe}, {15'h0, e_oe});
            chk("R3 model dq_out", dq_out, e_dq);
            chk("R5 model rfsh", {12'h0, rfsh, rfsh_row & {3{rfsh}}}, {12'h0, m_rfsh, m_rrow & {3{m_rfsh}}});
        end
    end

    // ---------------- stimulus helpers ----------------
    task automatic drv(input logic r, c, t, wl, wu, ds, input logic [2:0] a, input logic [15:0] d);
        ras_n = r; cas_n = c; trg_n = t; wel_n = wl; weu_n = wu; dsf = ds; addr = a; dq_in = d;
    endtask

    task automatic idle(input int n);
        drv(1, 1, 1, 1, 1, 1, 3'd0, 16'h0);
        repeat (n) @(negedge clk);
    endtask

    task automatic reg_load(input logic sel, input logic [15:0] v, input bit late, input logic [2:0] row);
        idle(1);
        drv(0, 1, 1, 1, 1, 1, row, 16'h0); @(negedge clk);
        if (!late) drv(0, 0, 1, 0, 0, sel, row, v);
        else       drv(0, 0, 1, 1, 1, sel, row, 16'h0);
        repeat (2) @(negedge clk);
        if (late) begin
            drv(0, 0, 1, 0, 1, sel, row, v);
            repeat (2) @(negedge clk);
        end
        idle(2);
    endtask

    task automatic reg_read(input logic sel, input logic [2:0] row, output logic [15:0] v, output logic oe);
        idle(1);
        drv(0, 1, 1, 1, 1, 1, row, 16'h0); @(negedge clk);
        drv(0, 0, 1, 1, 1, sel, row, 16'h0);
        repeat (2) @(negedge clk);
        v = dq_out; oe = dq_oe;
        drv(0, 1, 1, 1, 1, sel, row, 16'h0);
        #1 chk("R4 oe drops with column strobe rise", {15'h0, dq_oe}, 16'h0);
        @(negedge clk);
        idle(2);
    endtask

    task automatic flash(input logic [2:0] row);
        idle(1);
        drv(0, 1, 1, 0, 0, 1, row, 16'h0);
        repeat (2) @(negedge clk);
        idle(2);
    endtask

    task automatic arr_write(input logic [2:0] row, input logic [1:0] col, input logic [15:0] v, input logic [1:0] be);
        idle(1);
        drv(0, 1, 1, 1, 1, 0, row, 16'h0); @(negedge clk);
        drv(0, 0, 1, !be[0], !be[1], 0, {1'b0, col}, v);
        repeat (2) @(negedge clk);
        idle(2);
    endtask

    task automatic arr_read(input logic [2:0] row, input logic [1:0] col, output logic [15:0] v);
        idle(1);
        drv(0, 1, 1, 1, 1, 0, row, 16'h0); @(negedge clk);
        drv(0, 0, 1, 1, 1, 0, {1'b0, col}, 16'h0);
        repeat (2) @(negedge clk);
        v = dq_out;
        idle(2);
    endtask

    // ---------------- watchdog ----------------
    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            tests++; fails++;
            $display("FAIL watchdog actual=hung expected=finished");
            $display("[TB] %0d tests run, %0d failed", tests, fails);
            $finish;
        end
    end

    // ---------------- directed and random sequences ----------------
    initial begin
        logic [15:0] v;
        logic        oe;
        logic [15:0] lf;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R9: reset state
        chk("R9 dq_oe after reset", {15'h0, dq_oe}, 16'h0);
        chk("R9 rfsh after reset", {15'h0, rfsh}, 16'h0);
        reg_read(1'b1, 3'd0, v, oe); chk("R9 color cleared", v, 16'h0);
        reg_read(1'b0, 3'd0, v, oe); chk("R9 mask cleared", v, 16'h0);
        arr_read(3'd6, 2'd2, v);     chk("R9 array cleared", v, 16'h0);

        // R1/R3: color load and read, plus R2 late write enable on mask
        reg_load(1'b1, 16'hA5C3, 1'b0, 3'd1);
        reg_read(1'b1, 3'd1, v, oe);
        chk("R1 color read", v, 16'hA5C3);
        chk("R3 oe during read", {15'h0, oe}, 16'h1);
        reg_load(1'b0, 16'h0FF0, 1'b1, 3'd2);
        reg_read(1'b0, 3'd2, v, oe); chk("R2 late-WE mask load", v, 16'h0FF0);
        reg_read(1'b1, 3'd2, v, oe); chk("R1 color untouched by mask load", v, 16'hA5C3);

        // R5: refresh pulse for register cycle, none for plain cycle
        idle(1);
        drv(0, 1, 1, 1, 1, 1, 3'd5, 16'h0); @(negedge clk);
        chk("R5 rfsh pulse", {15'h0, rfsh}, 16'h1);
        chk("R5 rfsh row", {13'h0, rfsh_row}, 16'd5);
        @(negedge clk);
        chk("R5 rfsh one clock", {15'h0, rfsh}, 16'h0);
        idle(2);
        drv(0, 1, 1, 1, 1, 0, 3'd4, 16'h0); @(negedge clk);
        chk("R5 no rfsh in plain cycle", {15'h0, rfsh}, 16'h0);
        idle(2);

        // R7: plain writes, full word and low byte only
        arr_write(3'd2, 2'd1, 16'h1234, 2'b11);
        arr_read(3'd2, 2'd1, v); chk("R7 plain full write", v, 16'h1234);
        arr_write(3'd2, 2'd3, 16'hFFAB, 2'b01);
        arr_read(3'd2, 2'd3, v); chk("R7 low byte lane only", v, 16'h00AB);
        arr_write(3'd2, 2'd3, 16'h7E00, 2'b10);
        arr_read(3'd2, 2'd3, v); chk("R7 high byte lane only", v, 16'h7EAB);

        // R6: masked flash of row 2 (color A5C3, mask 0FF0)
        flash(3'd2);
        arr_read(3'd2, 2'd0, v); chk("R6 flash col0", v, 16'h05C0);
        arr_read(3'd2, 2'd1, v); chk("R6 flash keeps unmasked col1", v, 16'h15C4);
        arr_read(3'd2, 2'd3, v); chk("R6 flash keeps unmasked col3", v, 16'h75CB);
        arr_read(3'd3, 2'd1, v); chk("R6 other row untouched", v, 16'h0000);

        // R8: column strobe with row strobe high does nothing
        drv(1, 0, 1, 0, 0, 1, 3'd0, 16'hFFFF);
        repeat (3) @(negedge clk);
        chk("R8 no bus drive without row strobe", {15'h0, dq_oe}, 16'h0);
        idle(2);
        reg_read(1'b1, 3'd0, v, oe); chk("R8 color kept after stray column strobe", v, 16'hA5C3);
        // R8: transfer strobe low at row fall -> no-op
        drv(0, 1, 0, 1, 1, 1, 3'd1, 16'h0); @(negedge clk);
        drv(0, 0, 0, 0, 0, 1, 3'd1, 16'h1111);
        repeat (2) @(negedge clk);
        chk("R8 illegal pattern no drive", {15'h0, dq_oe}, 16'h0);
        idle(2);
        reg_read(1'b1, 3'd0, v, oe); chk("R8 color kept after illegal pattern", v, 16'hA5C3);

        // R4: row-strobe rise ends a read in the same cycle
        drv(0, 1, 1, 1, 1, 1, 3'd0, 16'h0); @(negedge clk);
        drv(0, 0, 1, 1, 1, 0, 3'd0, 16'h0); repeat (2) @(negedge clk);
        chk("R4 oe in mask read", {15'h0, dq_oe}, 16'h1);
        ras_n = 1'b1;
        #1 chk("R4 oe drops with row strobe rise", {15'h0, dq_oe}, 16'h0);
        idle(2);

        // pseudo-random strobe activity against the model
        lf = 16'hACE1;
        for (int i = 0; i < 3000; i++) begin
            lf = {lf[14:0], lf[15] ^ lf[13] ^ lf[12] ^ lf[10]};
            if (lf[2:0] == 3'd0) ras_n = ~ras_n;
            if (lf[4:3] == 2'd0) cas_n = ~cas_n;
            if (lf[8:6] == 3'd0) wel_n = ~wel_n;
            if (lf[11:9] == 3'd0) weu_n = ~weu_n;
            if (lf[14:12] == 3'd0) dsf = ~dsf;
            trg_n = (lf[15:13] != 3'd0);
            addr  = lf[7:5];
            dq_in = {lf[7:0], lf[15:8]} ^ 16'h5A5A;
            @(negedge clk);
        end
        idle(3);

        done = 1'b1;
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

endmodule